// File: doc/BRIEF.md
# PCI Target Command and Burst Address Decoder

This block follows the address phase of a 32-bit PCI target. On the clock edge that closes the address phase it captures the bus command, the address and the device-select input. It then decides whether to claim the transaction and reports which kind of access it is. For the rest of the transaction it keeps a dword address that moves forward by one data phase each time the data path reports a completed transfer.

Memory commands are claimed only when the address falls inside a base/mask window. Configuration commands are claimed only when the device-select input is high. Several read and write commands fold onto plain memory read or memory write. Each memory command has its own rule on whether cache-line wrapping applies. The two low address bits choose the burst order. A reserved order is still claimed, but the target asks to disconnect after the first data phase. The captured state stays on the outputs until a frame-end strobe clears it.

Top module: `pci_tdec_top`

## Requirements
- R1: While reset is low, and after it, until the first address phase: `claim`=0, `acc_type`=0, `dw_addr`=0, `wrap_active`=0, `disc_req`=0.
- R2: Commands 0110, 1100 and 1110 give `acc_type`=1 (memory read). Commands 0111 and 1111 give `acc_type`=2 (memory write). In both cases the address must be inside the window, and `dw_addr` loads address bits [31:2].
- R3: A memory command is claimed only if `(ad_in & win_mask) == (win_base & win_mask)`. When the command is not claimed, every output is 0.
- R4: Command 1010 gives `acc_type`=3 (configuration read) and command 1011 gives `acc_type`=4 (configuration write). They are claimed only when `idsel` is 1. `dw_addr` loads `ad_in[7:2]` with all upper bits 0, and each data phase adds 1 modulo 64.
- R5: Every other command code is never claimed, whatever the address and `idsel` are. This includes the reserved codes 1000 and 1001 and dual address cycle 1101.
- R6: For commands 0110, 0111, 1100 and 1111 with `ad_in[1:0]`=10, `wrap_active` is 1. Each data phase then adds 1 to `dw_addr` modulo 2^L and keeps the bits at L and above. L is `line_lg` clamped to MAX_LINE_LG.
- R7: Command 1110 always bursts linearly with `wrap_active`=0, even when `ad_in[1:0]`=10.
- R8: A claimed memory command with `ad_in[1:0]` equal to 01 or 11 sets `disc_req`=1. `dw_addr` then ignores `data_step`, so only the first data phase is addressed.
- R9: The outputs load on the clock edge where `addr_phase` is 1 and hold until the edge where `frame_end` is 1. When both are 1 on the same edge, `addr_phase` wins. `data_step` has no effect while nothing is claimed.
- R10: A linear memory burst adds 1 per `data_step` and rolls over from all ones to 0 across the full 30-bit dword range. Configuration commands ignore `ad_in[1:0]`: `wrap_active`=0 and `disc_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase | input | 1 | High for the clock that ends the address phase |
| cmd_in | input | 4 | Bus command captured with the address |
| ad_in | input | ADDR_W | Address captured in the address phase |
| idsel | input | 1 | Device select for configuration commands |
| data_step | input | 1 | One data phase completed |
| frame_end | input | 1 | Transaction finished; clears the outputs |
| win_base | input | ADDR_W | Memory window base |
| win_mask | input | ADDR_W | Memory window compare mask |
| line_lg | input | LG_W | log2 of the cache-line size in dwords |
| claim | output | 1 | Transaction claimed |
| acc_type | output | 3 | 0 none, 1 mem read, 2 mem write, 3 cfg read, 4 cfg write |
| dw_addr | output | ADDR_W-2 | Dword address of the current data phase |
| wrap_active | output | 1 | Burst wraps within the cache line |
| disc_req | output | 1 | Disconnect after the first data phase |

## Verification
The bench builds the block with ADDR_W=32 and MAX_LINE_LG=4. With those values `line_lg` is 3 bits wide and can request 5, 6 or 7. That makes the clamp to a 16-dword line reachable, along with wrap lines of 1, 4, 8 and 16 dwords. The 32-bit address also lets a zero window mask exercise the linear rollover of the 30-bit dword address. A configuration burst starting at offset 63 exercises the 64-dword wrap of the configuration offset.

// File: rtl/pci_tdec_pkg.sv
package pci_tdec_pkg;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_MRD  = 3'd1,
    ACC_MWR  = 3'd2,
    ACC_CRD  = 3'd3,
    ACC_CWR  = 3'd4
  } acc_e;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_LIN  = 2'd1,
    AM_WRAP = 2'd2,
    AM_CFG  = 2'd3
  } amode_e;

  localparam int CFG_OFS_W = 6;

  function automatic logic acc_is_mem(acc_e a);
    return (a == ACC_MRD) || (a == ACC_MWR);
  endfunction

  function automatic logic acc_is_cfg(acc_e a);
    return (a == ACC_CRD) || (a == ACC_CWR);
  endfunction

endpackage

// File: rtl/pci_tdec_cmd.sv
module pci_tdec_cmd
  import pci_tdec_pkg::*;
(
  input  logic [3:0] cmd,
  output acc_e       acc,
  output logic       wrap_ok
);

  always_comb begin
    acc     = ACC_NONE;
    wrap_ok = 1'b0;
    unique case (cmd)
      4'b0110: begin acc = ACC_MRD; wrap_ok = 1'b1; end
      4'b0111: begin acc = ACC_MWR; wrap_ok = 1'b1; end
      4'b1100: begin acc = ACC_MRD; wrap_ok = 1'b1; end
      4'b1110: begin acc = ACC_MRD; wrap_ok = 1'b0; end
      4'b1111: begin acc = ACC_MWR; wrap_ok = 1'b1; end
      4'b1010: acc = ACC_CRD;
      4'b1011: acc = ACC_CWR;
      default: begin acc = ACC_NONE; wrap_ok = 1'b0; end
    endcase
  end

endmodule

// File: rtl/pci_tdec_claim.sv
module pci_tdec_claim
  import pci_tdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  acc_e              acc,
  input  logic [ADDR_W-1:0] ad,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              idsel,
  input  logic              wrap_ok,
  output logic              claim_ok,
  output logic              wrap_en,
  output logic              disc_en
);

  logic in_win;
  logic mem_cmd;
  logic cfg_cmd;
  logic ord_wrap;
  logic ord_rsvd;

  assign in_win   = ((ad & mask) == (base & mask));
  assign mem_cmd  = acc_is_mem(acc);
  assign cfg_cmd  = acc_is_cfg(acc);
  assign ord_wrap = (ad[1:0] == 2'b10);
  assign ord_rsvd = ad[0];

  always_comb begin
    claim_ok = 1'b0;
    wrap_en  = 1'b0;
    disc_en  = 1'b0;
    if (mem_cmd && in_win) begin
      claim_ok = 1'b1;
      wrap_en  = ord_wrap && wrap_ok;
      disc_en  = ord_rsvd;
    end else if (cfg_cmd && idsel) begin
      claim_ok = 1'b1;
    end
  end

endmodule

// File: rtl/pci_tdec_addr_gen.sv
module pci_tdec_addr_gen
  import pci_tdec_pkg::*;
#(
  parameter int DW_W        = 30,
  parameter int MAX_LINE_LG = 5,
  parameter int LG_W        = $clog2(MAX_LINE_LG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  amode_e          load_mode,
  input  logic [DW_W-1:0] load_addr,
  input  logic [LG_W-1:0] load_lg,
  input  logic            clear,
  input  logic            step,
  output logic [DW_W-1:0] addr,
  output logic [LG_W-1:0] lg_q
);

  localparam logic [LG_W-1:0] LG_MAX = LG_W'(MAX_LINE_LG);

  amode_e          mode_q, mode_d;
  logic [DW_W-1:0] addr_q, addr_d;
  logic [LG_W-1:0] lg_d;
  logic [DW_W-1:0] line_mask;
  logic [DW_W-1:0] cfg_mask;
  logic [DW_W-1:0] addr_inc;
  logic [31:0]     lg_ext;

  assign lg_ext   = 32'(lg_q);
  assign addr_inc = addr_q + 1'b1;

  for (genvar gi = 0; gi < DW_W; gi++) begin : gen_mask
    assign line_mask[gi] = (lg_ext > 32'(gi));
    assign cfg_mask[gi]  = (gi < CFG_OFS_W);
  end

  always_comb begin
    mode_d = mode_q;
    addr_d = addr_q;
    lg_d   = lg_q;
    if (load) begin
      mode_d = load_mode;
      addr_d = load_addr;
      lg_d   = (load_lg > LG_MAX) ? LG_MAX : load_lg;
    end else if (clear) begin
      mode_d = AM_HOLD;
      addr_d = '0;
      lg_d   = '0;
    end else if (step) begin
      unique case (mode_q)
        AM_LIN:  addr_d = addr_inc;
        AM_WRAP: addr_d = (addr_q & ~line_mask) | (addr_inc & line_mask);
        AM_CFG:  addr_d = addr_inc & cfg_mask;
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_HOLD;
      addr_q <= '0;
      lg_q   <= '0;
    end else begin
      mode_q <= mode_d;
      addr_q <= addr_d;
      lg_q   <= lg_d;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/pci_tdec_top.sv
module pci_tdec_top
  import pci_tdec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_LINE_LG = 5,
  parameter int LG_W        = $clog2(MAX_LINE_LG + 1),
  parameter int DW_W        = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase,
  input  logic [3:0]        cmd_in,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              idsel,
  input  logic              data_step,
  input  logic              frame_end,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic [LG_W-1:0]   line_lg,
  output logic              claim,
  output logic [2:0]        acc_type,
  output logic [DW_W-1:0]   dw_addr,
  output logic              wrap_active,
  output logic              disc_req
);

  acc_e            dec_acc;
  logic            dec_wrap_ok;
  logic            claim_ok;
  logic            wrap_en;
  logic            disc_en;
  amode_e          ld_mode;
  logic [DW_W-1:0] ld_addr;
  logic [LG_W-1:0] line_lg_q;

  logic claim_q, claim_d;
  acc_e acc_q, acc_d;
  logic wrap_q, wrap_d;
  logic disc_q, disc_d;

  pci_tdec_cmd u_cmd (
    .cmd     (cmd_in),
    .acc     (dec_acc),
    .wrap_ok (dec_wrap_ok)
  );

  pci_tdec_claim #(.ADDR_W(ADDR_W)) u_claim (
    .acc      (dec_acc),
    .ad       (ad_in),
    .base     (win_base),
    .mask     (win_mask),
    .idsel    (idsel),
    .wrap_ok  (dec_wrap_ok),
    .claim_ok (claim_ok),
    .wrap_en  (wrap_en),
    .disc_en  (disc_en)
  );

  always_comb begin
    ld_mode = AM_HOLD;
    ld_addr = '0;
    if (claim_ok) begin
      if (acc_is_cfg(dec_acc)) begin
        ld_mode = AM_CFG;
        ld_addr = DW_W'(ad_in[7:2]);
      end else begin
        ld_addr = ad_in[ADDR_W-1:2];
        if (disc_en)      ld_mode = AM_HOLD;
        else if (wrap_en) ld_mode = AM_WRAP;
        else              ld_mode = AM_LIN;
      end
    end
  end

  pci_tdec_addr_gen #(
    .DW_W        (DW_W),
    .MAX_LINE_LG (MAX_LINE_LG),
    .LG_W        (LG_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_phase),
    .load_mode (ld_mode),
    .load_addr (ld_addr),
    .load_lg   (line_lg),
    .clear     (frame_end),
    .step      (data_step),
    .addr      (dw_addr),
    .lg_q      (line_lg_q)
  );

  always_comb begin
    claim_d = claim_q;
    acc_d   = acc_q;
    wrap_d  = wrap_q;
    disc_d  = disc_q;
    if (addr_phase) begin
      claim_d = claim_ok;
      acc_d   = claim_ok ? dec_acc : ACC_NONE;
      wrap_d  = wrap_en;
      disc_d  = disc_en;
    end else if (frame_end) begin
      claim_d = 1'b0;
      acc_d   = ACC_NONE;
      wrap_d  = 1'b0;
      disc_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      acc_q   <= ACC_NONE;
      wrap_q  <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      claim_q <= claim_d;
      acc_q   <= acc_d;
      wrap_q  <= wrap_d;
      disc_q  <= disc_d;
    end
  end

  assign claim       = claim_q;
  assign acc_type    = acc_q;
  assign wrap_active = wrap_q;
  assign disc_req    = disc_q;

endmodule

// File: rtl/pci_tdec_chk.sv
module pci_tdec_chk #(
  parameter int ADDR_W = 32,
  parameter int LG_W   = 3,
  parameter int DW_W   = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_phase,
  input logic [3:0]        cmd_in,
  input logic [ADDR_W-1:0] ad_in,
  input logic              idsel,
  input logic              data_step,
  input logic              frame_end,
  input logic              claim,
  input logic [2:0]        acc_type,
  input logic [DW_W-1:0]   dw_addr,
  input logic              wrap_active,
  input logic              disc_req,
  input logic [LG_W-1:0]   line_lg_q
);

  logic [DW_W-1:0] hi_mask;
  logic            quiet;

  assign hi_mask = ~((DW_W'(1) << line_lg_q) - DW_W'(1));
  assign quiet   = !addr_phase && !frame_end;

  AST_RESERVED_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && (cmd_in == 4'b1000 || cmd_in == 4'b1001 || cmd_in == 4'b1101) |=> !claim) // R5
    else $error("reserved command claimed");

  AST_CFG_NEEDS_IDSEL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && cmd_in[3:1] == 3'b101 && !idsel |=> !claim) // R4
    else $error("config claimed without idsel");

  AST_MRL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && cmd_in == 4'b1110 |=> !wrap_active) // R7
    else $error("memory read line wrapped");

  AST_CLEAR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !addr_phase |=> !claim && acc_type == 3'd0 && !wrap_active && !disc_req) // R9
    else $error("frame end did not clear");

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && !data_step |=> $stable(dw_addr) && $stable(acc_type) && $stable(claim)) // R9
    else $error("outputs moved without a strobe");

  AST_DISC_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req && quiet |=> $stable(dw_addr)) // R8
    else $error("address advanced after disconnect");

  AST_WRAP_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_active && quiet && data_step |=> (dw_addr & hi_mask) == ($past(dw_addr) & hi_mask)) // R6
    else $error("wrap changed upper bits");

  AST_LINEAR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    claim && (acc_type == 3'd1 || acc_type == 3'd2) && !wrap_active && !disc_req && quiet && data_step
    |=> dw_addr == $past(dw_addr) + 1'b1) // R10
    else $error("linear burst did not increment");

  AST_NO_CLAIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |-> acc_type == 3'd0 && dw_addr == '0 && !wrap_active && !disc_req) // R3
    else $error("unclaimed outputs not zero");

endmodule

bind pci_tdec_top pci_tdec_chk #(.ADDR_W(ADDR_W), .LG_W(LG_W), .DW_W(DW_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_phase  (addr_phase),
  .cmd_in      (cmd_in),
  .ad_in       (ad_in),
  .idsel       (idsel),
  .data_step   (data_step),
  .frame_end   (frame_end),
  .claim       (claim),
  .acc_type    (acc_type),
  .dw_addr     (dw_addr),
  .wrap_active (wrap_active),
  .disc_req    (disc_req),
  .line_lg_q   (line_lg_q)
);

// File: tb/test_pci_tdec_top.sv
`timescale 1ns/1ps
module test_pci_tdec_top;

  localparam int ADDR_W = 32;
  localparam int MAXLG  = 4;
  localparam int LG_W   = $clog2(MAXLG + 1);
  localparam int DW_W   = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              addr_phase = 1'b0;
  logic [3:0]        cmd_in = '0;
  logic [ADDR_W-1:0] ad_in = '0;
  logic              idsel = 1'b0;
  logic              data_step = 1'b0;
  logic              frame_end = 1'b0;
  logic [ADDR_W-1:0] win_base = 32'h8000_0000;
  logic [ADDR_W-1:0] win_mask = 32'hF000_0000;
  logic [LG_W-1:0]   line_lg = '0;
  logic              claim;
  logic [2:0]        acc_type;
  logic [DW_W-1:0]   dw_addr;
  logic              wrap_active;
  logic              disc_req;

  always #4 clk = ~clk;

  pci_tdec_top #(.ADDR_W(ADDR_W), .MAX_LINE_LG(MAXLG)) i_pci_tdec_top (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .cmd_in(cmd_in), .ad_in(ad_in),
    .idsel(idsel), .data_step(data_step), .frame_end(frame_end), .win_base(win_base),
    .win_mask(win_mask), .line_lg(line_lg), .claim(claim), .acc_type(acc_type),
    .dw_addr(dw_addr), .wrap_active(wrap_active), .disc_req(disc_req)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  bit      m_claim, m_wrap, m_disc, m_cfg;
  int      m_acc;
  longint  m_addr;
  int      m_line;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_claim = 0; m_wrap = 0; m_disc = 0; m_cfg = 0; m_acc = 0; m_addr = 0; m_line = 1;
    end else if (addr_phase) begin
      int  a;
      bit  wok, ok;
      a = 0; wok = 0;
      case (int'(cmd_in))
        6:  begin a = 1; wok = 1; end
        7:  begin a = 2; wok = 1; end
        12: begin a = 1; wok = 1; end
        14: begin a = 1; wok = 0; end
        15: begin a = 2; wok = 1; end
        10: a = 3;
        11: a = 4;
        default: a = 0;
      endcase
      if (a == 1 || a == 2) ok = ((ad_in & win_mask) == (win_base & win_mask));
      else if (a >= 3)      ok = idsel;
      else                  ok = 0;
      m_claim = ok;
      m_acc   = ok ? a : 0;
      m_cfg   = ok && a >= 3;
      m_wrap  = ok && a <= 2 && wok && ad_in[1:0] == 2'b10;
      m_disc  = ok && a <= 2 && ad_in[0];
      m_line  = 1 << ((int'(line_lg) > MAXLG) ? MAXLG : int'(line_lg));
      if (!ok)        m_addr = 0;
      else if (m_cfg) m_addr = (ad_in >> 2) % 64;
      else            m_addr = ad_in >> 2;
    end else if (frame_end) begin
      m_claim = 0; m_wrap = 0; m_disc = 0; m_cfg = 0; m_acc = 0; m_addr = 0;
    end else if (data_step && m_claim && !m_disc) begin
      if (m_cfg)       m_addr = (m_addr + 1) % 64;
      else if (m_wrap) m_addr = m_addr - (m_addr % m_line) + ((m_addr % m_line) + 1) % m_line;
      else             m_addr = (m_addr + 1) % (longint'(1) << DW_W);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (claim !== m_claim || int'(acc_type) != m_acc || longint'(dw_addr) != m_addr ||
          wrap_active !== m_wrap || disc_req !== m_disc) begin
        n_err++;
        $display("FAIL %s t=%0t: claim=%0b acc=%0d addr=%h wrap=%0b disc=%0b expected claim=%0b acc=%0d addr=%h wrap=%0b disc=%0b",
                 cur_req, $time, claim, acc_type, dw_addr, wrap_active, disc_req,
                 m_claim, m_acc, m_addr[DW_W-1:0], m_wrap, m_disc);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic start(input logic [3:0] c, input logic [31:0] a, input bit sel, input int lg);
    cmd_in = c; ad_in = a; idsel = sel; line_lg = LG_W'(lg); addr_phase = 1'b1;
    tick();
    addr_phase = 1'b0; cmd_in = '0; ad_in = '0; idsel = 1'b0;
  endtask

  task automatic steps(input int n);
    data_step = 1'b1;
    repeat (n) tick();
    data_step = 1'b0;
  endtask

  task automatic fend();
    frame_end = 1'b1; tick(); frame_end = 1'b0; tick();
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();
    steps(2);

    cur_req = "R2";
    start(4'b0110, 32'h8000_0100, 0, 2); steps(3); fend();
    start(4'b0111, 32'h8123_4560, 0, 2); steps(3); fend();
    start(4'b1100, 32'h8000_0040, 0, 2); steps(2); fend();
    start(4'b1111, 32'h8000_0080, 0, 2); steps(2); fend();

    cur_req = "R3";
    start(4'b0110, 32'h9000_0000, 1, 2); steps(2); fend();
    start(4'b1111, 32'h7FFF_FFF0, 1, 2); steps(2); fend();

    cur_req = "R6";
    start(4'b0110, 32'h8000_000A, 0, 2); steps(5); fend();
    start(4'b1100, 32'h8000_0116, 0, 3); steps(9); fend();
    start(4'b0111, 32'h8000_0202, 0, 0); steps(3); fend();
    start(4'b1111, 32'h8000_033E, 0, 7); steps(18); fend();

    cur_req = "R7";
    start(4'b1110, 32'h8000_000E, 0, 2); steps(5); fend();

    cur_req = "R8";
    start(4'b0110, 32'h8000_0011, 0, 2); steps(3); fend();
    start(4'b1111, 32'h8000_0023, 0, 2); steps(3); fend();

    cur_req = "R4";
    start(4'b1010, 32'h0000_00FC, 1, 2); steps(3); fend();
    start(4'b1011, 32'h1234_5610, 1, 2); steps(2); fend();
    start(4'b1011, 32'h0000_0010, 0, 2); steps(2); fend();

    cur_req = "R5";
    for (int c = 0; c < 16; c++) begin
      start(4'(c), 32'h8000_0040, 1, 2); steps(1); fend();
    end

    cur_req = "R9";
    steps(3);
    start(4'b0110, 32'h8000_0500, 0, 2); steps(1);
    start(4'b0111, 32'h8000_0600, 0, 2); steps(1);
    frame_end = 1'b1; start(4'b1010, 32'h0000_0020, 1, 2); frame_end = 1'b0;
    tick(); steps(2); fend();

    cur_req = "R10";
    win_mask = '0;
    start(4'b0110, 32'hFFFF_FFF8, 0, 2); steps(3); fend();
    start(4'b1010, 32'h0000_0012, 1, 2); steps(2); fend();
    start(4'b1011, 32'h0000_0007, 1, 2); steps(2); fend();

    repeat (2) tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule